// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This peripheral drives a parameterised number of pulse-width-modulated outputs from one shared 16-bit counter. A prescaler divides the input clock by a power of two and a small counter state machine (states `CNT_STOPPED`, `CNT_UP`, `CNT_DOWN`) steps the counter on each prescaled tick. In edge-aligned operation the counter climbs from 0 to a terminal count and wraps. In center-aligned operation it climbs to the terminal count and then falls back to 0. Each channel compares the live count with its own threshold and produces an output whose polarity and enable come from a 2-bit polarity-select field in its control register.

Software reaches every register through a 32-bit word bus: a write strobe with address and data, and a read path that returns data combinationally for the presented address. The terminal count and the channel thresholds are double-buffered. While the counter is halted a write reaches the working copy at once. While it runs, the write waits in a buffer until the period boundary, so one period never mixes an old period length with a new duty value.

State machine transitions:
- `CNT_STOPPED`→`CNT_UP` on the first tick after the counter is enabled.
- `CNT_UP`→`CNT_UP` on an increment, or on the wrap to 0 in edge mode.
- `CNT_UP`→`CNT_DOWN` on reaching the terminal count in center mode.
- `CNT_DOWN`→`CNT_UP` on reaching 0.
- Any state→`CNT_STOPPED` when the clock mode is not 01 or when the counter register is written.

Top module: `pwm_bank`

## Requirements
- R1: The read-only register at 0x04 returns the number of implemented channels in bits [7:0]. After reset every register reads 0 and every output is low.
- R2: The control register at 0x10 holds:
  - bits [2:0]: the prescale code;
  - bits [4:3]: the clock mode;
  - bit 5: the center-aligned select.
  Its fields read back as written.
- R3: The counter advances only when the clock mode is 01. Codes 00, 10 and 11 hold the counter at its present value.
- R4: When running, the counter advances once every 2^code input clocks. A code written while halted applies from the start. A code written while running takes effect from the next prescaled tick.
- R5: In edge-aligned mode the counter counts 0,1,…,M and then returns to 0, where M is the working terminal count.
- R6: In center-aligned mode the counter counts up to M, then down to 0, then up again. For M=3 starting from 0 the sequence is 1,2,3,2,1,0,1,2,3,2.
- R7: A write to the terminal count register at 0x18 (bits [15:0]) takes effect at once while halted. While running, it is held and transferred when the counter leaves M: to 0 in edge mode, or to M-1 in center mode. A read returns the last written value.
- R8: Channel n threshold writes (0x24+8n, bits [15:0]) follow the same buffering and transfer rule as the terminal count. A read returns the last written value.
- R9: An enabled channel of normal polarity outputs high while count < threshold. A threshold of 0 gives a constant low. A threshold above M gives a constant high.
- R10: The channel n control register is at 0x20+8n. The channel is enabled only when bit 5 is 1 and bit 4 is 0, with bits [3:2] equal to 10 (normal) or 01 (inverted, the exact complement). Any other combination drives the output low. A control write changes the output in the cycle after the write edge.
- R11: Bit 7 of the channel control register is an event flag. It sets when a prescaled tick occurs while the running counter equals the working threshold. Writing 1 to bit 7 clears it; writing 0 leaves it unchanged.
- R12: Any write to the counter register at 0x14 resets the count to 0 and restarts the prescaler. Reads of 0x14 return the live count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | Per-channel PWM outputs |

## Verification
The bench writes a new terminal count and a new threshold while the counter is running. A design that applied these writes at once would wrap early or shift the falling edge inside the current period; the bench catches both. It counts prescaled ticks exactly after a fresh start, so a one-clock offset in the divider shows up. It also changes the code mid-run, which would expose a divider that stalls. The center-aligned sequence around the terminal count and 0 catches a doubled or skipped turn-around value. Thresholds of 0 and above the terminal count, reserved polarity-field combinations, and writing 0 versus 1 to the event flag target the places where a comparison off by one or a mis-decoded field changes the outputs.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
    // prescale code width; bit positions of the control fields depend on it
    localparam int PS_W        = 3;
    localparam int OFS_PARAM   = 'h04;
    localparam int OFS_CTRL    = 'h10;
    localparam int OFS_CNT     = 'h14;
    localparam int OFS_MOD     = 'h18;
    localparam int OFS_CH_BASE = 'h20;
    localparam int CH_STRIDE   = 8;
    localparam int CH_VAL_OFS  = 4;

    localparam logic [1:0] CLK_RUN  = 2'b01;
    localparam logic [1:0] POL_NORM = 2'b10;
    localparam logic [1:0] POL_INV  = 2'b01;

    typedef enum logic [1:0] {
        CNT_STOPPED = 2'd0,
        CNT_UP      = 2'd1,
        CNT_DOWN    = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] code_in,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;
    logic [DIV_W:0]   one_sh;
    logic [PS_W-1:0]  code_act;

    always_comb begin
        one_sh = (DIV_W+1)'(1) << code_act;
        limit  = DIV_W'(one_sh - (DIV_W+1)'(1));
        tick   = run && (div_cnt == limit);
    end

    // the working code only changes while halted or on a tick boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            code_act <= '0;
        end else if (clr || !run || tick) begin
            div_cnt  <= '0;
            code_act <= code_in;
        end else begin
            div_cnt  <= div_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_cnt_fsm.sv
`timescale 1ns/1ps
module pwm_cnt_fsm
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             center,
    input  logic             tick,
    input  logic             clr,
    input  logic             mod_we,
    input  logic [CNT_W-1:0] mod_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] mod_buf,
    output logic [CNT_W-1:0] mod_act,
    output logic             load
);
    cnt_state_e state, nxt_state, up_state;
    logic [CNT_W-1:0] nxt_cnt, up_cnt;
    logic             up_load;

    // result of an upward step (also used when leaving CNT_STOPPED)
    always_comb begin
        up_load  = 1'b0;
        up_state = CNT_UP;
        up_cnt   = cnt + CNT_W'(1);
        if (cnt >= mod_act) begin
            up_load = 1'b1;
            if (center && (mod_act != '0)) begin
                up_cnt   = mod_act - CNT_W'(1);
                up_state = CNT_DOWN;
            end else begin
                up_cnt   = '0;
            end
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        load      = 1'b0;
        if (!run) begin
            nxt_state = CNT_STOPPED;
        end else if (tick) begin
            unique case (state)
                CNT_STOPPED, CNT_UP: begin
                    nxt_state = up_state;
                    nxt_cnt   = up_cnt;
                    load      = up_load;
                end
                CNT_DOWN: begin
                    if (!center) begin
                        nxt_state = up_state;
                        nxt_cnt   = up_cnt;
                        load      = up_load;
                    end else if (cnt == '0) begin
                        nxt_state = CNT_UP;
                        nxt_cnt   = (mod_act == '0) ? '0 : CNT_W'(1);
                    end else begin
                        nxt_cnt   = cnt - CNT_W'(1);
                    end
                end
                default: nxt_state = CNT_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CNT_STOPPED;
            cnt   <= '0;
        end else if (clr) begin
            state <= CNT_STOPPED;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_buf <= '0;
            mod_act <= '0;
        end else begin
            if (load) mod_act <= mod_buf;
            if (mod_we) begin
                mod_buf <= mod_wdata;
                if (!run) mod_act <= mod_wdata;
            end
        end
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             val_we,
    input  logic             wr_flag_clr,
    input  logic             wr_sel_hi,
    input  logic             wr_sel_lo,
    input  logic [1:0]       wr_pol,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             run,
    input  logic             match_en,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       ctrl_rd,
    output logic [CNT_W-1:0] val_rd,
    output logic             on,
    output logic             pwm
);
    logic             flag, sel_hi, sel_lo;
    logic [1:0]       pol;
    logic [CNT_W-1:0] val_buf, val_act;
    logic             on_norm, on_inv, below;

    always_comb begin
        on_norm = sel_hi && !sel_lo && (pol == POL_NORM);
        on_inv  = sel_hi && !sel_lo && (pol == POL_INV);
        on      = on_norm || on_inv;
        below   = cnt < val_act;
        pwm     = on_norm ? below : (on_inv ? !below : 1'b0);
        ctrl_rd = {flag, 1'b0, sel_hi, sel_lo, pol, 2'b00};
        val_rd  = val_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_hi <= 1'b0;
            sel_lo <= 1'b0;
            pol    <= 2'b00;
            flag   <= 1'b0;
        end else begin
            if (ctrl_we) begin
                sel_hi <= wr_sel_hi;
                sel_lo <= wr_sel_lo;
                pol    <= wr_pol;
            end
            if (match_en && (cnt == val_act)) flag <= 1'b1;
            else if (ctrl_we && wr_flag_clr)  flag <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_buf <= '0;
            val_act <= '0;
        end else begin
            if (load) val_act <= val_buf;
            if (val_we) begin
                val_buf <= wr_val;
                if (!run) val_act <= wr_val;
            end
        end
    end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [PS_W-1:0]  presc;
    logic [1:0]       clk_mode;
    logic             center, run, tick, cnt_clr, mod_we, load;
    logic [CNT_W-1:0] cnt, mod_buf, mod_act;
    logic [NCH-1:0]   ch_on;
    logic [7:0]       ch_ctrl_rd [NCH];
    logic [CNT_W-1:0] ch_val_rd  [NCH];
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata[31:CNT_W];

    function automatic logic [ADDR_W-1:0] ch_addr(input int idx, input bit is_val);
        return ADDR_W'(OFS_CH_BASE + CH_STRIDE * idx + (is_val ? CH_VAL_OFS : 0));
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc    <= '0;
            clk_mode <= 2'b00;
            center   <= 1'b0;
        end else if (bus_wen && (bus_addr == ADDR_W'(OFS_CTRL))) begin
            presc    <= bus_wdata[PS_W-1:0];
            clk_mode <= bus_wdata[PS_W+1:PS_W];
            center   <= bus_wdata[PS_W+2];
        end
    end

    assign run     = (clk_mode == CLK_RUN);
    assign cnt_clr = bus_wen && (bus_addr == ADDR_W'(OFS_CNT));
    assign mod_we  = bus_wen && (bus_addr == ADDR_W'(OFS_MOD));

    pwm_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(cnt_clr),
        .code_in(presc), .tick(tick)
    );

    pwm_cnt_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .center(center), .tick(tick),
        .clr(cnt_clr), .mod_we(mod_we), .mod_wdata(bus_wdata[CNT_W-1:0]),
        .cnt(cnt), .mod_buf(mod_buf), .mod_act(mod_act), .load(load)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we(bus_wen && (bus_addr == ch_addr(i, 1'b0))),
            .val_we(bus_wen && (bus_addr == ch_addr(i, 1'b1))),
            .wr_flag_clr(bus_wdata[7]), .wr_sel_hi(bus_wdata[5]),
            .wr_sel_lo(bus_wdata[4]), .wr_pol(bus_wdata[3:2]),
            .wr_val(bus_wdata[CNT_W-1:0]),
            .run(run), .match_en(run && tick && !cnt_clr), .load(load), .cnt(cnt),
            .ctrl_rd(ch_ctrl_rd[i]), .val_rd(ch_val_rd[i]),
            .on(ch_on[i]), .pwm(pwm_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_PARAM)) bus_rdata = 32'(8'(NCH));
        if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = 32'({center, clk_mode, presc});
        if (bus_addr == ADDR_W'(OFS_CNT))   bus_rdata = 32'(cnt);
        if (bus_addr == ADDR_W'(OFS_MOD))   bus_rdata = 32'(mod_buf);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ch_addr(i, 1'b0)) bus_rdata = 32'(ch_ctrl_rd[i]);
            if (bus_addr == ch_addr(i, 1'b1)) bus_rdata = 32'(ch_val_rd[i]);
        end
    end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             center,
    input logic             tick,
    input logic             cnt_clr,
    input logic             load,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] mod_act,
    input logic [NCH-1:0]   ch_on,
    input logic [NCH-1:0]   pwm_out
);
    p_hold_halted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_clr) |=> $stable(cnt));

    p_tick_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick && !cnt_clr) |=> $stable(cnt));

    p_edge_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !center && !cnt_clr && (cnt < mod_act))
        |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

    p_edge_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !center && !cnt_clr && (cnt >= mod_act)) |=> (cnt == '0));

    p_load_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (run && tick));

    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_off
        p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_on[i] |-> !pwm_out[i]);
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .center(center), .tick(tick),
    .cnt_clr(cnt_clr), .load(load), .cnt(cnt), .mod_act(mod_act),
    .ch_on(ch_on), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    pwm_bank u_pwm_bank (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2.5 clk = ~clk;

    localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18;
    function automatic logic [7:0] a_chc(input int n); return 8'(8'h20 + 8 * n); endfunction
    function automatic logic [7:0] a_chv(input int n); return 8'(8'h24 + 8 * n); endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic halt_and_clear();
        wr(A_CTRL, 32'h00);
        wr(A_CNT, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_PARAM, d); check("R1 param", d, NCH);
        rd(A_CTRL, d);  check("R1 ctrl reset", d, 0);
        rd(A_CNT, d);   check("R1 cnt reset", d, 0);
        rd(A_MOD, d);   check("R1 mod reset", d, 0);
        check("R1 outputs reset", 32'(pwm_out), 0);
    endtask

    task automatic t_halted_writes();
        logic [31:0] d;
        wr(A_MOD, 32'd9);
        wr(a_chv(0), 32'd3);
        wr(a_chc(0), 32'h28);
        rd(A_MOD, d);     check("R7 mod readback", d, 9);
        rd(a_chv(0), d);  check("R8 value readback", d, 3);
        rd(a_chc(0), d);  check("R10 ctrl readback", d, 32'h28);
        check("R9 immediate output while halted", 32'(pwm_out[0]), 1);
        wr(A_CTRL, 32'h05);
        rd(A_CTRL, d);    check("R2 ctrl readback", d, 32'h05);
        wait_n(5);
        rd(A_CNT, d);     check("R3 halted counter holds", d, 0);
        wr(A_CTRL, 32'h00);
    endtask

    task automatic t_edge_run();
        logic [31:0] d, c0;
        wr(A_CTRL, 32'h08);
        for (int k = 1; k <= 21; k++) begin
            @(negedge clk);
            rd(A_CNT, d);
            check("R5 edge count", d, k % 10);
            check("R9 normal output", 32'(pwm_out[0]), 32'((k % 10) < 3));
        end
        wr(A_CTRL, 32'h10);
        rd(A_CNT, c0);
        wait_n(3);
        rd(A_CNT, d); check("R3 reserved mode holds", d, c0);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        wr(A_CTRL, 32'h08);
        wr(A_CNT, 32'h1234);
        rd(A_CNT, d); check("R12 clear", d, 0);
        @(negedge clk);
        rd(A_CNT, d); check("R12 live after clear", d, 1);
    endtask

    task automatic t_polarity();
        logic [31:0] c;
        wr(a_chc(0), 32'h24);
        rd(A_CNT, c);
        check("R10 inverted", 32'(pwm_out[0]), 32'(!(c < 3)));
        wr(a_chc(0), 32'h38);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R10 bit4 set disables", 32'(pwm_out[0]), 0);
        end
        wr(a_chc(0), 32'h00);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R10 field 00 low", 32'(pwm_out[0]), 0);
        end
        wr(a_chc(0), 32'h28);
    endtask

    task automatic t_limits();
        wr(a_chv(2), 32'd20); wr(a_chc(2), 32'h28);
        wr(a_chv(3), 32'd0);  wr(a_chc(3), 32'h28);
        wait_n(12);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check("R9 threshold above M high", 32'(pwm_out[2]), 1);
            check("R9 threshold 0 low", 32'(pwm_out[3]), 0);
        end
    endtask

    task automatic t_mod_buffer();
        logic [31:0] d;
        bit seen;
        halt_and_clear();
        wr(A_MOD, 32'd9);
        wr(A_CTRL, 32'h08);
        wr(A_MOD, 32'd4);
        rd(A_MOD, d); check("R7 buffered readback", d, 4);
        seen = 1'b0;
        for (int k = 0; k < 20 && !seen; k++) begin
            rd(A_CNT, d);
            if (d == 9) seen = 1'b1; else @(negedge clk);
        end
        check("R7 old M used to period end", 32'(seen), 1);
        @(negedge clk); rd(A_CNT, d); check("R7 wrap after old M", d, 0);
        wait_n(4);      rd(A_CNT, d); check("R7 new M reached", d, 4);
        @(negedge clk); rd(A_CNT, d); check("R7 wrap at new M", d, 0);
    endtask

    task automatic t_val_buffer();
        logic [31:0] c, d;
        wr(a_chv(0), 32'd1);
        rd(A_CNT, c);
        check("R8 old threshold kept", 32'(pwm_out[0]), 32'(c < 3));
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rd(A_CNT, d);
            if (d == 0) break;
        end
        wait_n(2);
        rd(A_CNT, d); check("R8 cnt position", d, 2);
        check("R8 new threshold after boundary", 32'(pwm_out[0]), 0);
        rd(a_chv(0), d); check("R8 value readback", d, 1);
    endtask

    task automatic t_center();
        logic [31:0] d;
        int exp_seq [10] = '{1, 2, 3, 2, 1, 0, 1, 2, 3, 2};
        halt_and_clear();
        wr(A_MOD, 32'd3);
        wr(A_CTRL, 32'h28);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rd(A_CNT, d);
            check("R6 center sequence", d, exp_seq[k]);
        end
    endtask

    task automatic t_prescale();
        logic [31:0] d, c0;
        halt_and_clear();
        wr(A_MOD, 32'd100);
        wr(A_CTRL, 32'h02);
        wr(A_CTRL, 32'h0A);
        wait_n(3); rd(A_CNT, d); check("R4 no tick before 4 clocks", d, 0);
        wait_n(1); rd(A_CNT, d); check("R4 first tick", d, 1);
        wait_n(4); rd(A_CNT, d); check("R4 second tick", d, 2);
        wr(A_CTRL, 32'h08);
        wait_n(6);
        rd(A_CNT, c0);
        @(negedge clk); rd(A_CNT, d); check("R4 new code applied", d, c0 + 1);
        @(negedge clk); rd(A_CNT, d); check("R4 new code steady", d, c0 + 2);
    endtask

    task automatic t_flag();
        logic [31:0] d;
        halt_and_clear();
        wr(A_MOD, 32'd9);
        wr(a_chv(1), 32'd2);
        wr(a_chc(1), 32'h80);
        rd(a_chc(1), d); check("R11 cleared", d, 0);
        wr(A_CTRL, 32'h08);
        wait_n(2); rd(a_chc(1), d); check("R11 not yet set", d, 0);
        wait_n(1); rd(a_chc(1), d); check("R11 set on match", d, 32'h80);
        wr(A_CTRL, 32'h00);
        wr(a_chc(1), 32'h00);
        rd(a_chc(1), d); check("R11 write 0 keeps flag", d, 32'h80);
        wr(a_chc(1), 32'h80);
        rd(a_chc(1), d); check("R11 write 1 clears", d, 0);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_halted_writes();
        t_edge_run();
        t_clear();
        t_polarity();
        t_limits();
        t_mod_buffer();
        t_val_buffer();
        t_center();
        t_prescale();
        t_flag();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule